// File: doc/BRIEF.md
# Polled Character Terminal Port

This block gives a processor one character input channel and one character output channel through four word registers at the top of the address space. Each direction has a status word and a data word. The status word holds a ready flag and a software-writable interrupt enable. Software can poll the ready flag, or it can set the enable and wait for the shared interrupt line.

Characters arrive from the keyboard side as a byte with a one-cycle valid pulse. A processor read of the receive data word consumes the character. A processor store to the transmit data word hands the low byte to the display side, which holds a request until the display acknowledges it. The ready flags change only as side effects of these accesses and of the two side handshakes.

The bus port is synchronous. Read data is combinational and is valid in the same cycle as the read strobe. Writes take effect at the next clock edge.

Top module: `term_mmio`

## Requirements
- R1: The map is receive status at 0xFFFF0000, receive data at 0xFFFF0004, transmit status at 0xFFFF0008 and transmit data at 0xFFFF000C. In each status word, bit 0 is ready, bit 1 is interrupt enable and all bits above those defined read 0. Receive data returns the character in bits 7:0 with zeros above. Transmit data reads as 0. busRdata is 0 whenever busRd is low.
- R2: A kbdValid pulse stores kbdData and sets receive ready (status bit 0) from the next cycle.
- R3: A read of receive data returns the stored character and, unless kbdValid is high in the same cycle, clears receive ready from the next cycle.
- R4: A kbdValid pulse that arrives while receive ready is 1, and that does not coincide with a receive data read, overwrites the character and sets overrun (receive status bit 2). A receive data read clears overrun.
- R5: A store to transmit data while transmit ready is 1 drives bits 7:0 onto dispData and raises dispValid from the next cycle. Transmit ready reads 0 from then on, and both outputs hold until dispDone.
- R6: dispDone while dispValid is high drops dispValid and sets transmit ready from the next cycle.
- R7: A store to transmit data while transmit ready is 0 has no effect on dispData or dispValid.
- R8: Only bit 1 of each status word is writable. Writes to the ready and overrun positions are ignored.
- R9: irq is high exactly when (receive ready AND receive enable) OR (transmit ready AND transmit enable).
- R10: Reads of any other address return 0. Writes to any other address change no register.
- R11: After reset both status words read with enable 0, receive ready 0, overrun 0 and transmit ready 1. irq and dispValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| busAddr | input | 32 | byte address of the access |
| busRd | input | 1 | read strobe |
| busWr | input | 1 | write strobe |
| busWdata | input | 32 | write data |
| busRdata | output | 32 | read data, valid in the cycle busRd is high |
| kbdData | input | 8 | incoming character |
| kbdValid | input | 1 | one-cycle pulse that delivers kbdData |
| dispData | output | 8 | outgoing character |
| dispValid | output | 1 | character waiting for the display |
| dispDone | input | 1 | display has taken the character |
| irq | output | 1 | interrupt request |

## Verification
The assertions assume that busRd and busWr are never high together. They also assume that kbdValid is a single-cycle pulse and that dispDone is raised only while dispValid is high.

The bench drives every strobe for exactly one cycle, which keeps within these assumptions. It issues the overrun case with two pulses several cycles apart, so the second pulse never meets a receive data read. It raises dispDone only after it has checked that a character is pending.

// File: rtl/termio_pkg.sv
package termio_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_STAT,
    SEL_RX_CHAR,
    SEL_TX_STAT,
    SEL_TX_CHAR
  } rdSel_e;

  typedef struct packed {
    logic rxStatWr;
    logic rxCharRd;
    logic txStatWr;
    logic txCharWr;
  } strobes_t;

  localparam int unsigned READY_BIT = 0;
  localparam int unsigned IE_BIT    = 1;
  localparam int unsigned OVR_BIT   = 2;
endpackage

// File: rtl/term_ctrl.sv
module term_ctrl
  import termio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output strobes_t          strb,
  output rdSel_e            rdSel
);
  localparam int unsigned SLOT_LSB = 2;
  localparam int unsigned PAGE_LSB = 4;
  localparam logic [ADDR_W-1:0] BASE_W = BASE_ADDR[ADDR_W-1:0];

  logic       hit;
  logic [1:0] slot;

  assign hit  = (busAddr[ADDR_W-1:PAGE_LSB] == BASE_W[ADDR_W-1:PAGE_LSB])
                && (busAddr[SLOT_LSB-1:0] == '0);
  assign slot = busAddr[PAGE_LSB-1:SLOT_LSB];

  always_comb begin
    strb  = '0;
    rdSel = SEL_NONE;
    if (hit) begin
      unique case (slot)
        2'd0: begin strb.rxStatWr = busWr; if (busRd) rdSel = SEL_RX_STAT; end
        2'd1: begin strb.rxCharRd = busRd; if (busRd) rdSel = SEL_RX_CHAR; end
        2'd2: begin strb.txStatWr = busWr; if (busRd) rdSel = SEL_TX_STAT; end
        default: begin strb.txCharWr = busWr; if (busRd) rdSel = SEL_TX_CHAR; end
      endcase
    end
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr) |-> $onehot0(strb));

  // R10
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (strb == '0) && (rdSel == SEL_NONE));
endmodule

// File: rtl/term_dp.sv
module term_dp
  import termio_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CHAR_W-1:0] kbdData,
  input  logic              kbdValid,
  output logic [CHAR_W-1:0] dispData,
  output logic              dispValid,
  input  logic              dispDone,
  output logic              irq
);
  logic [CHAR_W-1:0] rxChar;
  logic              rxReady, rxOvr, rxIe;
  logic              txBusy, txIe;
  logic [CHAR_W-1:0] txChar;
  logic              txReady;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:CHAR_W];
  assign txReady     = !txBusy;

  // receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxChar  <= '0;
      rxReady <= 1'b0;
      rxOvr   <= 1'b0;
      rxIe    <= 1'b0;
    end else begin
      if (strb.rxStatWr) rxIe <= busWdata[IE_BIT];
      if (kbdValid) begin
        rxChar  <= kbdData;
        rxReady <= 1'b1;
        if (strb.rxCharRd)  rxOvr <= 1'b0;
        else if (rxReady)   rxOvr <= 1'b1;
      end else if (strb.rxCharRd) begin
        rxReady <= 1'b0;
        rxOvr   <= 1'b0;
      end
    end
  end

  // transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txChar <= '0;
      txBusy <= 1'b0;
      txIe   <= 1'b0;
    end else begin
      if (strb.txStatWr) txIe <= busWdata[IE_BIT];
      if (txBusy) begin
        if (dispDone) txBusy <= 1'b0;
      end else if (strb.txCharWr) begin
        txChar <= busWdata[CHAR_W-1:0];
        txBusy <= 1'b1;
      end
    end
  end

  assign dispData  = txChar;
  assign dispValid = txBusy;
  assign irq       = (rxReady && rxIe) || (txReady && txIe);

  always_comb begin
    busRdata = '0;
    unique case (rdSel)
      SEL_RX_STAT: begin
        busRdata[READY_BIT] = rxReady;
        busRdata[IE_BIT]    = rxIe;
        busRdata[OVR_BIT]   = rxOvr;
      end
      SEL_RX_CHAR: busRdata[CHAR_W-1:0] = rxChar;
      SEL_TX_STAT: begin
        busRdata[READY_BIT] = txReady;
        busRdata[IE_BIT]    = txIe;
      end
      default: busRdata = '0;
    endcase
  end

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    kbdValid |=> rxReady && (rxChar == $past(kbdData)));

  // R3
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCharRd && !kbdValid |=> !rxReady);

  // R4
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    kbdValid && rxReady && !strb.rxCharRd |=> rxOvr);

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && !dispDone |=> dispValid && $stable(dispData));

  // R6
  tx_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid && dispDone |=> !dispValid);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxIe && !txIe |-> !irq);
endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import termio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CHAR_W    = 8,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CHAR_W-1:0] kbdData,
  input  logic              kbdValid,
  output logic [CHAR_W-1:0] dispData,
  output logic              dispValid,
  input  logic              dispDone,
  output logic              irq
);
  strobes_t strb;
  rdSel_e   rdSel;

  term_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .strb(strb), .rdSel(rdSel)
  );

  term_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .busWdata(busWdata),
    .busRdata(busRdata), .kbdData(kbdData), .kbdValid(kbdValid),
    .dispData(dispData), .dispValid(dispValid), .dispDone(dispDone), .irq(irq)
  );
endmodule

// File: tb/sim_term_mmio.sv
module sim_term_mmio;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  kbdData = '0;
  logic        kbdValid = 1'b0;
  logic [7:0]  dispData;
  logic        dispValid;
  logic        dispDone = 1'b0;
  logic        irq;

  int nChecks = 0, nFails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  localparam logic [31:0] RXS = 32'hFFFF_0000, RXD = 32'hFFFF_0004,
                          TXS = 32'hFFFF_0008, TXD = 32'hFFFF_000C;

  always #5 clk = ~clk;

  term_mmio u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read as it happens
  always @(negedge clk) begin
    if (busRd) begin
      if (expQ.size() == 0) chk("unexpected read", busRdata, 32'h0);
      else chk(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic busRead(logic [31:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    busAddr = a; busRd = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic busWrite(logic [31:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic kbdSend(logic [7:0] b);
    @(posedge clk); #1;
    kbdData = b; kbdValid = 1'b1;
    @(posedge clk); #1;
    kbdValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(posedge clk); #1;
    dispDone = 1'b1;
    @(posedge clk); #1;
    dispDone = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got hang expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R11 irq", {31'b0, irq}, 32'h0);
    chk("R11 dispValid", {31'b0, dispValid}, 32'h0);
    busRead(RXS, 32'h0, "R11 rx status");
    busRead(TXS, 32'h1, "R11 tx status");

    // R2 R3 R1
    kbdSend(8'h41);
    busRead(RXS, 32'h1, "R2 rx ready set");
    busRead(RXD, 32'h41, "R3 R1 rx char");
    busRead(RXS, 32'h0, "R3 rx ready cleared");
    @(negedge clk);
    chk("R1 idle rdata", busRdata, 32'h0);

    // R4 overrun
    kbdSend(8'h10);
    repeat (2) @(posedge clk);
    kbdSend(8'h22);
    busRead(RXS, 32'h5, "R4 overrun flag");
    busRead(RXD, 32'h22, "R4 overwrite");
    busRead(RXS, 32'h0, "R4 overrun cleared");

    // R8 R9
    busWrite(RXS, 32'hFFFF_FFFF);
    busRead(RXS, 32'h2, "R8 rx ie only");
    @(negedge clk);
    chk("R9 irq rx ie no ready", {31'b0, irq}, 32'h0);
    busWrite(TXS, 32'h2);
    busRead(TXS, 32'h3, "R8 tx ie");
    @(negedge clk);
    chk("R9 irq tx ready", {31'b0, irq}, 32'h1);
    busWrite(TXS, 32'h0);
    @(negedge clk);
    chk("R9 irq tx ie off", {31'b0, irq}, 32'h0);
    kbdSend(8'h55);
    @(negedge clk);
    chk("R9 irq rx ready", {31'b0, irq}, 32'h1);
    busRead(RXD, 32'h55, "R3 rx char 2");
    @(negedge clk);
    chk("R9 irq after read", {31'b0, irq}, 32'h0);

    // R5 R6 R7
    busWrite(TXD, 32'h1234_5678);
    @(negedge clk);
    chk("R5 dispValid", {31'b0, dispValid}, 32'h1);
    chk("R5 dispData", {24'b0, dispData}, 32'h78);
    busRead(TXS, 32'h0, "R5 tx not ready");
    busRead(TXD, 32'h0, "R1 tx data reads zero");
    busWrite(TXD, 32'h99);
    @(negedge clk);
    chk("R7 dispData kept", {24'b0, dispData}, 32'h78);
    chk("R7 dispValid kept", {31'b0, dispValid}, 32'h1);
    pulseDone();
    @(negedge clk);
    chk("R6 dispValid low", {31'b0, dispValid}, 32'h0);
    busRead(TXS, 32'h1, "R6 tx ready");
    busWrite(TXD, 32'hA5);
    @(negedge clk);
    chk("R5 second char", {24'b0, dispData}, 32'hA5);
    pulseDone();

    // R10
    busWrite(32'hFFFF_0010, 32'hFFFF_FFFF);
    busWrite(32'hFFFF_0002, 32'hFFFF_FFFF);
    busRead(32'hFFFF_0010, 32'h0, "R10 unmapped read");
    busRead(32'h0000_0008, 32'h0, "R10 low page read");
    busRead(RXS, 32'h2, "R10 rx status untouched");
    busRead(TXS, 32'h1, "R10 tx status untouched");
    @(negedge clk);
    chk("R10 no tx started", {31'b0, dispValid}, 32'h0);

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule